// File: doc/BRIEF.md
# Range-Matching Translation Buffer with Pinned Block Slots

This block is a fully associative translation buffer. Each entry maps a contiguous virtual range to a physical base. An ordinary entry covers a power-of-four multiple of the page size. A pinned block entry covers any whole number of pages. A lookup is purely combinational. It returns the matching slot, the translated physical address and the attribute fields stored with the entry.

All changes go through one command port. The port accepts one command per clock, and the effect is visible from the next cycle. There are six commands:
- ordinary insert;
- range purge;
- purge of all ordinary entries;
- block insert;
- block purge of one slot;
- block purge of all slots.

The low `BLOCKS` slots are pinned. Only the three block commands touch them. Ordinary inserts use a free slot when one exists. When none is free, a round-robin pointer that never points into the pinned slots picks the victim. Permission checking and fault reporting belong to the logic that consumes the lookup outputs.

Top module: `range_tlb`

## Requirements
- R1: A lookup hits slot i when slot i is valid and start ≤ `lk_va` ≤ last. When several slots match, the lowest slot index is reported. `lk_pa` equals the slot's physical base plus (`lk_va` − start), truncated to `PA_W` bits. On a miss every lookup output is zero.
- R2: An ordinary insert (`cmd_op`=0) with exponent n=`cmd_size` covers 2^(`PAGE_BITS`+2n) bytes. The start is `cmd_va` with the low `PAGE_BITS`+2n bits cleared, and last is start plus size minus one.
- R3: The physical base of an ordinary insert is {`cmd_ppn`, `PAGE_BITS` zero bits}. Its low `PAGE_BITS`+2n bits are cleared, and bits at or above `PA_W` are dropped.
- R4: The attribute word `cmd_acc` is decoded as follows: T at bit 61, D at bit 60, B at bit 59, rights type at bits 58:56, PL1 at bits 55:54, PL2 at bits 53:52, U at bit 51, access ID at bits 31:1.
- R5: An ordinary insert first invalidates every valid non-pinned slot whose range overlaps the new range. It then allocates.
- R6: A range purge (`cmd_op`=1) takes its exponent from `cmd_va[3:0]` and its base from `cmd_va` aligned as in R2. Exponent 0 covers exactly one page. It invalidates every overlapping non-pinned slot.
- R7: Ordinary inserts, range purges and purge-all never change the pinned slots 0 to `BLOCKS`−1.
- R8: Allocation picks the lowest-index invalid non-pinned slot, counting slots freed by R5. If no slot is free, it takes the round-robin slot. The pointer then advances by one and wraps from `ENTRIES`−1 back to `BLOCKS`. After reset the pointer is `BLOCKS`.
- R9: Purge-all (`cmd_op`=2) invalidates every non-pinned slot and returns the round-robin pointer to `BLOCKS`.
- R10: A block insert (`cmd_op`=3) writes slot `cmd_slot` and replaces whatever that slot held. The range starts at page `cmd_va[VA_W-1:PAGE_BITS]` and spans `cmd_len` pages (≥1). The physical base is {`cmd_ppn`, zeros} truncated to `PA_W`. Attributes come from R4, except that T is forced to 0 and D to 1. A block insert or block purge with `cmd_slot` ≥ `BLOCKS` changes nothing and raises `blk_err` in the next cycle for one cycle.
- R11: A block purge (`cmd_op`=4) invalidates pinned slot `cmd_slot`. A block purge-all (`cmd_op`=5) invalidates every pinned slot and leaves ordinary slots intact.
- R12: After reset all slots are invalid, every lookup misses and `blk_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Some valid slot covers lk_va |
| lk_slot | output | SLOT_W | Lowest matching slot |
| lk_pa | output | PA_W | Translated physical address |
| lk_t | output | 1 | Stored T attribute |
| lk_d | output | 1 | Stored D attribute |
| lk_b | output | 1 | Stored B attribute |
| lk_rights | output | 3 | Stored rights type |
| lk_pl1 | output | 2 | Stored PL1 |
| lk_pl2 | output | 2 | Stored PL2 |
| lk_u | output | 1 | Stored U attribute |
| lk_aid | output | 31 | Stored access ID |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 insert, 1 range purge, 2 purge-all, 3 block insert, 4 block purge, 5 block purge-all |
| cmd_va | input | VA_W | Virtual address (carries the exponent for range purge) |
| cmd_size | input | 4 | Size exponent for ordinary insert |
| cmd_ppn | input | PPN_W | Physical page number |
| cmd_acc | input | 64 | Attribute word |
| cmd_slot | input | SLOT_W | Pinned slot index |
| cmd_len | input | LEN_W | Block length in pages |
| blk_err | output | 1 | Invalid slot on the previous block command |

## Verification
The bench builds the block with six slots, two of them pinned, a 32-bit virtual space and a 24-bit physical space. With four ordinary slots, the free-slot path runs out after four inserts. The round-robin pointer then wraps within four more, so both allocation paths and the wrap to the first non-pinned slot are exercised. The narrow physical width makes the dropping of upper page-number bits visible. A pinned entry placed over an ordinary one exercises lowest-index priority and survival across range purges and purge-all.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [2:0] {
    OP_INSERT        = 3'd0,
    OP_PURGE_RANGE   = 3'd1,
    OP_PURGE_ALL     = 3'd2,
    OP_BLK_INSERT    = 3'd3,
    OP_BLK_PURGE     = 3'd4,
    OP_BLK_PURGE_ALL = 3'd5
  } tlb_op_e;

  typedef struct packed {
    logic        t;
    logic        d;
    logic        b;
    logic [2:0]  rights;
    logic [1:0]  pl1;
    logic [1:0]  pl2;
    logic        u;
    logic [30:0] aid;
  } tlb_attr_t;

  // hi carries attribute word bits 61:51, aid carries bits 31:1
  function automatic tlb_attr_t attr_from_word(input logic [10:0] hi,
                                               input logic [30:0] aid);
    tlb_attr_t a;
    a.t      = hi[10];
    a.d      = hi[9];
    a.b      = hi[8];
    a.rights = hi[7:5];
    a.pl1    = hi[4:3];
    a.pl2    = hi[2:1];
    a.u      = hi[0];
    a.aid    = aid;
    return a;
  endfunction

endpackage

// File: rtl/tlb_range_cmp.sv
module tlb_range_cmp #(
  parameter int N    = 8,
  parameter int VA_W = 40
) (
  input  logic [N-1:0]    valid_i,
  input  logic [VA_W-1:0] start_i [N],
  input  logic [VA_W-1:0] last_i  [N],
  input  logic [VA_W-1:0] probe_i,
  input  logic [VA_W-1:0] win_lo_i,
  input  logic [VA_W-1:0] win_hi_i,
  output logic [N-1:0]    hit_o,
  output logic [N-1:0]    ovl_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = valid_i[i] && (start_i[i] <= probe_i) && (probe_i <= last_i[i]);
    assign ovl_o[i] = valid_i[i] && (start_i[i] <= win_hi_i) && (last_i[i] >= win_lo_i);
  end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 8,
  parameter int B  = 2,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  free_i,
  input  logic          take_i,
  input  logic          flush_i,
  output logic [IW-1:0] victim_o
);
  localparam logic [IW-1:0] FIRST = IW'(B);
  localparam logic [IW-1:0] FINAL = IW'(N - 1);

  logic          any_free;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] rr_q;
  logic          rr_step;

  tlb_prio_enc #(.N(N), .IW(IW)) u_free (
    .vec_i(free_i), .found_o(any_free), .idx_o(free_idx)
  );

  assign victim_o = any_free ? free_idx : rr_q;
  assign rr_step  = take_i && !any_free;

  always_ff @(posedge clk) begin
    if (!rst_n || flush_i) rr_q <= FIRST;
    else if (rr_step)      rr_q <= (rr_q == FINAL) ? FIRST : rr_q + IW'(1);
  end

  AST_RR_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_q >= FIRST) && (rr_q <= FINAL)); // R8
  AST_RR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> rr_q == FIRST); // R9
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 16,
  parameter int BLOCKS    = 4,
  parameter int VA_W      = 40,
  parameter int PA_W      = 36,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 28,
  parameter int LEN_W     = 16,
  localparam int SLOT_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_slot,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_t,
  output logic              lk_d,
  output logic              lk_b,
  output logic [2:0]        lk_rights,
  output logic [1:0]        lk_pl1,
  output logic [1:0]        lk_pl2,
  output logic              lk_u,
  output logic [30:0]       lk_aid,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [3:0]        cmd_size,
  input  logic [PPN_W-1:0]  cmd_ppn,
  input  logic [63:0]       cmd_acc,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              blk_err
);
  localparam logic [ENTRIES-1:0] PIN_MASK = (ENTRIES'(1) << BLOCKS) - ENTRIES'(1);
  localparam logic [ENTRIES-1:0] NB_MASK  = ~PIN_MASK;
  localparam logic [SLOT_W-1:0]  SLOT_LIM = SLOT_W'(BLOCKS);

  // byte mask of a 2^(PAGE_BITS+2n) range in virtual space
  function automatic logic [VA_W-1:0] va_span(input logic [3:0] n);
    logic [VA_W-1:0] m;
    for (int i = 0; i < VA_W; i++) m[i] = (i < PAGE_BITS + 2 * int'(n));
    return m;
  endfunction

  function automatic logic [PA_W-1:0] pa_span(input logic [3:0] n);
    logic [PA_W-1:0] m;
    for (int i = 0; i < PA_W; i++) m[i] = (i < PAGE_BITS + 2 * int'(n));
    return m;
  endfunction

  function automatic logic [PA_W-1:0] page_to_pa(input logic [PPN_W-1:0] ppn);
    return PA_W'({ppn, {PAGE_BITS{1'b0}}});
  endfunction

  // entry storage
  logic [ENTRIES-1:0] valid_q;
  logic [VA_W-1:0]    start_q [ENTRIES];
  logic [VA_W-1:0]    last_q  [ENTRIES];
  logic [PA_W-1:0]    pa_q    [ENTRIES];
  tlb_attr_t          attr_q  [ENTRIES];

  // command decode
  tlb_op_e         op;
  logic [3:0]      win_exp;
  logic [VA_W-1:0] win_mask, win_lo, win_hi;
  logic [VA_W-1:0] blk_start, blk_last;
  tlb_attr_t       acc_attr, blk_attr;
  logic            unused_acc_bits;

  assign op        = tlb_op_e'(cmd_op);
  assign win_exp   = (op == OP_PURGE_RANGE) ? cmd_va[3:0] : cmd_size;
  assign win_mask  = va_span(win_exp);
  assign win_lo    = cmd_va & ~win_mask;
  assign win_hi    = win_lo | win_mask;
  assign blk_start = {cmd_va[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign blk_last  = blk_start + (VA_W'(cmd_len) << PAGE_BITS) - VA_W'(1);
  assign acc_attr  = attr_from_word(cmd_acc[61:51], cmd_acc[31:1]);
  always_comb begin
    blk_attr   = acc_attr;
    blk_attr.t = 1'b0;
    blk_attr.d = 1'b1;
  end
  assign unused_acc_bits = ^{cmd_acc[63:62], cmd_acc[50:32], cmd_acc[0]};

  // named internal events
  logic               do_insert, do_prange, do_pall;
  logic               do_blk_ins, do_blk_pur, do_blk_pall;
  logic               slot_ok;
  logic [ENTRIES-1:0] hit_vec, ovl_vec, kill_vec, free_vec;
  logic [SLOT_W-1:0]  victim;

  assign do_insert   = cmd_valid && (op == OP_INSERT);
  assign do_prange   = cmd_valid && (op == OP_PURGE_RANGE);
  assign do_pall     = cmd_valid && (op == OP_PURGE_ALL);
  assign do_blk_ins  = cmd_valid && (op == OP_BLK_INSERT);
  assign do_blk_pur  = cmd_valid && (op == OP_BLK_PURGE);
  assign do_blk_pall = cmd_valid && (op == OP_BLK_PURGE_ALL);
  assign slot_ok     = cmd_slot < SLOT_LIM;

  tlb_range_cmp #(.N(ENTRIES), .VA_W(VA_W)) u_cmp (
    .valid_i(valid_q), .start_i(start_q), .last_i(last_q),
    .probe_i(lk_va), .win_lo_i(win_lo), .win_hi_i(win_hi),
    .hit_o(hit_vec), .ovl_o(ovl_vec)
  );

  assign kill_vec = ovl_vec & NB_MASK;
  assign free_vec = (~valid_q | kill_vec) & NB_MASK;

  tlb_victim #(.N(ENTRIES), .B(BLOCKS), .IW(SLOT_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .free_i(free_vec),
    .take_i(do_insert), .flush_i(do_pall), .victim_o(victim)
  );

  // lookup
  logic              any_hit;
  logic [SLOT_W-1:0] hit_idx;
  tlb_attr_t         hit_attr;

  tlb_prio_enc #(.N(ENTRIES), .IW(SLOT_W)) u_hit (
    .vec_i(hit_vec), .found_o(any_hit), .idx_o(hit_idx)
  );

  assign hit_attr  = any_hit ? attr_q[hit_idx] : '0;
  assign lk_hit    = any_hit;
  assign lk_slot   = hit_idx;
  assign lk_pa     = any_hit ? pa_q[hit_idx] + PA_W'(lk_va - start_q[hit_idx]) : '0;
  assign lk_t      = hit_attr.t;
  assign lk_d      = hit_attr.d;
  assign lk_b      = hit_attr.b;
  assign lk_rights = hit_attr.rights;
  assign lk_pl1    = hit_attr.pl1;
  assign lk_pl2    = hit_attr.pl2;
  assign lk_u      = hit_attr.u;
  assign lk_aid    = hit_attr.aid;

  // state update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      blk_err <= 1'b0;
    end else begin
      blk_err <= (do_blk_ins || do_blk_pur) && !slot_ok;
      if (do_insert || do_prange) valid_q <= valid_q & ~kill_vec;
      if (do_insert) begin
        valid_q[victim] <= 1'b1;
        start_q[victim] <= win_lo;
        last_q[victim]  <= win_hi;
        pa_q[victim]    <= page_to_pa(cmd_ppn) & ~pa_span(cmd_size);
        attr_q[victim]  <= acc_attr;
      end
      if (do_pall)     valid_q <= valid_q & PIN_MASK;
      if (do_blk_pall) valid_q <= valid_q & NB_MASK;
      if (do_blk_pur && slot_ok) valid_q[cmd_slot] <= 1'b0;
      if (do_blk_ins && slot_ok) begin
        valid_q[cmd_slot] <= 1'b1;
        start_q[cmd_slot] <= blk_start;
        last_q[cmd_slot]  <= blk_last;
        pa_q[cmd_slot]    <= page_to_pa(cmd_ppn);
        attr_q[cmd_slot]  <= blk_attr;
      end
    end
  end

  AST_BLOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (do_insert || do_prange || do_pall) |=> (valid_q & PIN_MASK) == $past(valid_q & PIN_MASK)); // R7
  AST_BAD_SLOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((do_blk_ins || do_blk_pur) && !slot_ok) |=> blk_err); // R10
  AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    do_insert |=> valid_q[$past(victim)] && !PIN_MASK[$past(victim)]); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    do_pall |=> (valid_q & NB_MASK) == '0); // R9
endmodule

// File: tb/tb_range_tlb.sv
module tb_range_tlb;
  localparam int ENTRIES = 6, BLOCKS = 2, VA_W = 32, PA_W = 24;
  localparam int PAGE_BITS = 12, PPN_W = 20, LEN_W = 12, SLOT_W = 3;

  logic clk = 0, rst_n = 0;
  logic [VA_W-1:0] lk_va = '0;
  logic lk_hit, lk_t, lk_d, lk_b, lk_u;
  logic [SLOT_W-1:0] lk_slot;
  logic [PA_W-1:0] lk_pa;
  logic [2:0] lk_rights;
  logic [1:0] lk_pl1, lk_pl2;
  logic [30:0] lk_aid;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = '0;
  logic [VA_W-1:0] cmd_va = '0;
  logic [3:0] cmd_size = '0;
  logic [PPN_W-1:0] cmd_ppn = '0;
  logic [63:0] cmd_acc = '0;
  logic [SLOT_W-1:0] cmd_slot = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic blk_err;

  range_tlb #(.ENTRIES(ENTRIES), .BLOCKS(BLOCKS), .VA_W(VA_W), .PA_W(PA_W),
              .PAGE_BITS(PAGE_BITS), .PPN_W(PPN_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_slot(lk_slot),
    .lk_pa(lk_pa), .lk_t(lk_t), .lk_d(lk_d), .lk_b(lk_b), .lk_rights(lk_rights),
    .lk_pl1(lk_pl1), .lk_pl2(lk_pl2), .lk_u(lk_u), .lk_aid(lk_aid),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_va(cmd_va), .cmd_size(cmd_size),
    .cmd_ppn(cmd_ppn), .cmd_acc(cmd_acc), .cmd_slot(cmd_slot), .cmd_len(cmd_len),
    .blk_err(blk_err)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_acc(bit t, bit d, bit b, int rights, int pl1,
                                         int pl2, bit u, int aid);
    logic [63:0] w = '0;
    w[61] = t; w[60] = d; w[59] = b;
    w[58:56] = 3'(rights); w[55:54] = 2'(pl1); w[53:52] = 2'(pl2);
    w[51] = u; w[31:1] = 31'(aid);
    return w;
  endfunction

  // called at a falling edge; returns at the falling edge after the command takes effect
  task automatic cmd(int op, logic [31:0] va, int sz, int ppn, logic [63:0] acc,
                     int slot, int len);
    cmd_op = 3'(op); cmd_va = va; cmd_size = 4'(sz); cmd_ppn = PPN_W'(ppn);
    cmd_acc = acc; cmd_slot = SLOT_W'(slot); cmd_len = LEN_W'(len);
    cmd_valid = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic probe(string req, logic [31:0] va, bit hit, int slot, int pa);
    lk_va = va;
    #1;
    chk(req, lk_hit, hit);
    if (hit) begin
      chk(req, lk_slot, slot);
      chk(req, lk_pa, pa);
    end else begin
      chk(req, lk_pa, 0);
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [3:0]  sz;
    logic [19:0] ppn;
    logic [31:0] pva;
    logic [2:0]  slot;
    logic [23:0] pa;
  } vec_t;

  // ordinary inserts and the lookup expected right after each (R1 R2 R3 R8)
  localparam vec_t VECS [9] = '{
    '{32'h0001_2345, 4'd0, 20'h00ABC, 32'h0001_2345, 3'd2, 24'hABC345},
    '{32'h0034_5678, 4'd1, 20'h00127, 32'h0034_7FFF, 3'd3, 24'h127FFF},
    '{32'h1000_0000, 4'd2, 20'hFF123, 32'h1000_8001, 3'd4, 24'h128001},
    '{32'h2000_0000, 4'd0, 20'h00001, 32'h2000_0FFF, 3'd5, 24'h001FFF},
    '{32'h3000_0000, 4'd0, 20'h00002, 32'h3000_0000, 3'd2, 24'h002000},
    '{32'h4000_0000, 4'd0, 20'h00003, 32'h4000_0000, 3'd3, 24'h003000},
    '{32'h5000_0000, 4'd0, 20'h00004, 32'h5000_0000, 3'd4, 24'h004000},
    '{32'h6000_0000, 4'd0, 20'h00005, 32'h6000_0000, 3'd5, 24'h005000},
    '{32'h7000_0000, 4'd0, 20'h00006, 32'h7000_0000, 3'd2, 24'h006000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    probe("R12", 32'h0000_0000, 0, 0, 0);
    probe("R12", 32'h1234_5000, 0, 0, 0);
    chk("R12", blk_err, 0);

    for (int i = 0; i < 9; i++) begin
      cmd(0, VECS[i].va, int'(VECS[i].sz), int'(VECS[i].ppn), '0, 0, 0);
      probe("R8", VECS[i].pva, 1, int'(VECS[i].slot), int'(VECS[i].pa));
    end
    probe("R8", 32'h0001_2345, 0, 0, 0);

    // R5: overlap insert frees slot 4 and reuses it; slot 3 untouched
    cmd(0, 32'h5000_0000, 1, 32'h20, mk_acc(1, 0, 1, 3, 1, 0, 0, 32'h7FFF_FFFF), 0, 0);
    probe("R5", 32'h5000_3FFC, 1, 4, 32'h023FFC);
    chk("R4", lk_t, 1); chk("R4", lk_d, 0); chk("R4", lk_b, 1);
    chk("R4", lk_rights, 3); chk("R4", lk_pl1, 1); chk("R4", lk_aid, 31'h7FFF_FFFF);
    probe("R5", 32'h4000_0000, 1, 3, 32'h003000);
    probe("R5", 32'h6000_0000, 1, 5, 32'h005000);

    // R10: bad slots
    cmd(3, 32'h4000_0000, 0, 32'h99, '0, 3, 1);
    chk("R10", blk_err, 1);
    probe("R10", 32'h4000_0000, 1, 3, 32'h003000);
    cmd(4, '0, 0, 0, '0, 5, 0);
    chk("R10", blk_err, 1);
    probe("R10", 32'h6000_0000, 1, 5, 32'h005000);

    // R4/R10: block slot 0 with forced T/D
    cmd(3, 32'h0800_0000, 0, 32'h77, mk_acc(1, 0, 1, 5, 2, 1, 1, 32'h0123_4567), 0, 1);
    chk("R10", blk_err, 0);
    probe("R10", 32'h0800_0ABC, 1, 0, 32'h077ABC);
    chk("R10", lk_t, 0); chk("R10", lk_d, 1); chk("R4", lk_b, 1);
    chk("R4", lk_rights, 5); chk("R4", lk_pl1, 2); chk("R4", lk_pl2, 1);
    chk("R4", lk_u, 1); chk("R4", lk_aid, 31'h0123_4567);

    // R1: block slot 1 over slot 5, lowest index wins; R10 length
    cmd(3, 32'h6000_0000, 0, 32'hAA, '0, 1, 2);
    probe("R1", 32'h6000_0010, 1, 1, 32'h0AA010);
    probe("R10", 32'h6000_1004, 1, 1, 32'h0AB004);
    probe("R10", 32'h6000_2000, 0, 0, 0);

    // R6/R7 range purges
    cmd(1, 32'h6000_0000, 0, 0, '0, 0, 0);
    probe("R7", 32'h6000_0010, 1, 1, 32'h0AA010);
    cmd(1, 32'h4000_0001, 0, 0, '0, 0, 0);
    probe("R6", 32'h4000_0000, 0, 0, 0);
    cmd(1, 32'h5000_4000, 0, 0, '0, 0, 0);
    probe("R6", 32'h5000_0000, 1, 4, 32'h020000);
    cmd(1, 32'h5000_3000, 0, 0, '0, 0, 0);
    probe("R6", 32'h5000_0000, 0, 0, 0);

    // R11 block purge one: slot 5 was purged above, so region misses
    cmd(4, '0, 0, 0, '0, 1, 0);
    probe("R11", 32'h6000_0010, 0, 0, 0);

    // R9/R7 purge-all
    cmd(2, '0, 0, 0, '0, 0, 0);
    probe("R9", 32'h7000_0000, 0, 0, 0);
    probe("R7", 32'h0800_0ABC, 1, 0, 32'h077ABC);
    for (int i = 0; i < 4; i++) begin
      cmd(0, 32'h8000_0000 + (i << 24), 0, 32'h80 + i, '0, 0, 0);
      probe("R9", 32'h8000_0000 + (i << 24), 1, 2 + i, (32'h80 + i) << 12);
    end
    cmd(0, 32'h8400_0000, 0, 32'h84, '0, 0, 0);
    probe("R9", 32'h8400_0000, 1, 2, 32'h084000);
    probe("R9", 32'h8000_0000, 0, 0, 0);

    // R11 block purge-all
    cmd(3, 32'h9000_0000, 0, 32'h90, '0, 1, 4);
    probe("R11", 32'h9000_3000, 1, 1, 32'h093000);
    cmd(5, '0, 0, 0, '0, 0, 0);
    probe("R11", 32'h0800_0ABC, 0, 0, 0);
    probe("R11", 32'h9000_3000, 0, 0, 0);
    probe("R11", 32'h8100_0000, 1, 3, 32'h081000);

    // R2 large exponent, round-robin victim slot 3
    cmd(0, 32'hA123_4567, 3, 32'hC0, '0, 0, 0);
    probe("R2", 32'hA123_FFFF, 1, 3, 32'h0FFFFF);
    probe("R2", 32'hA120_0000, 1, 3, 32'h0C0000);
    probe("R2", 32'hA124_0000, 0, 0, 0);
    probe("R8", 32'h8100_0000, 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule